// File: doc/BRIEF.md
# FIFO Occupancy and Error Monitor

This block sits beside a synchronous FIFO and watches only its control handshake: the write and read strobes together with the full and empty indications. From these it rebuilds the FIFO fill level cycle by cycle. It also keeps the highest level reached, which is the figure used to decide whether the buffer is deep enough. A buffer that is too shallow overruns and loses payload, and one that is too deep wastes area.

Two kinds of misuse are logged separately. One is a write strobe while the FIFO reports full, an overflow attempt in which payload is lost. The other is a read strobe while the FIFO reports empty, an underflow attempt. Each kind has a sticky flag and a saturating event counter. One clear input restarts the statistics: it zeroes the flags and counters and restarts the high-water mark from the present level. The tracked level keeps following the FIFO through a clear.

Top module: `fifo_occ_monitor`

## Requirements
- R1: After reset the level, peak, both error flags and both error counters read zero.
- R2: A write strobe with `full` low and no accepted read in the same cycle raises `level` by one on the next clock edge, unless level already equals DEPTH.
- R3: A read strobe with `empty` low and no accepted write in the same cycle lowers `level` by one on the next clock edge, unless level is already zero.
- R4: When a write and a read are both accepted in the same cycle, `level` is unchanged.
- R5: A write strobe while `full` is high, or a read strobe while `empty` is high, does not change `level`.
- R6: `level` never leaves the range 0 to DEPTH. An accepted write at DEPTH leaves it at DEPTH, and an accepted read at zero leaves it at zero.
- R7: `peak` equals the largest `level` value seen since reset or since the last clear. It updates on the same edge as `level`.
- R8: A cycle with `wr_en` and `full` both high sets `ovf_flag`, which stays high until reset or clear.
- R9: A cycle with `rd_en` and `empty` both high sets `udf_flag`, which stays high until reset or clear.
- R10: Each error counter adds one for every cycle in which its error occurs and holds at 2^CNT_W-1. The two errors are counted independently, including when both occur in the same cycle.
- R11: With `clr` high at an edge, both flags and both counters become zero, and `peak` takes the level value produced by that same edge. `level` updates as usual. An error occurring in the clear cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the observed FIFO |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Restarts peak, flags and counters |
| wr_en | input | 1 | Observed FIFO write strobe |
| rd_en | input | 1 | Observed FIFO read strobe |
| full | input | 1 | Observed FIFO full indication |
| empty | input | 1 | Observed FIFO empty indication |
| level | output | $clog2(DEPTH+1) | Tracked fill level |
| peak | output | $clog2(DEPTH+1) | High-water mark |
| ovf_flag | output | 1 | Sticky write-while-full flag |
| udf_flag | output | 1 | Sticky read-while-empty flag |
| ovf_count | output | CNT_W | Saturating write-while-full count |
| udf_count | output | CNT_W | Saturating read-while-empty count |

## Verification
The hardest states to reach are the saturated error counters and a peak that sits exactly at DEPTH. Random traffic rarely holds an error condition long enough to saturate a counter, and it seldom fills the FIFO completely. Directed phases cover these: the FIFO is filled to the top, then left empty while more read strobes arrive than the counter can hold, and then a clear is issued in the same cycle as an overflow attempt. The random phase mostly drives full and empty consistently with the modelled level, and at times drives them inconsistently so that the clamping paths are exercised.

// File: rtl/fom_pkg.sv
package fom_pkg;

    // decoded handshake of one observed cycle
    typedef struct packed {
        logic wr_ok;   // write accepted by the FIFO
        logic rd_ok;   // read accepted by the FIFO
        logic ovf;     // write attempted while full
        logic udf;     // read attempted while empty
    } fom_evt_t;

    typedef enum logic [1:0] {
        LVL_HOLD = 2'd0,
        LVL_UP   = 2'd1,
        LVL_DOWN = 2'd2
    } lvl_step_e;

    localparam int unsigned ERR_KINDS = 2;
    localparam int unsigned ERR_OVF   = 0;
    localparam int unsigned ERR_UDF   = 1;

    function automatic lvl_step_e step_of(input logic wr_ok, input logic rd_ok);
        if (wr_ok && !rd_ok) return LVL_UP;
        if (rd_ok && !wr_ok) return LVL_DOWN;
        return LVL_HOLD;
    endfunction

endpackage

// File: rtl/fom_event_decode.sv
module fom_event_decode
    import fom_pkg::*;
(
    input  logic     wr_en,
    input  logic     rd_en,
    input  logic     full,
    input  logic     empty,
    output fom_evt_t evt
);
    always_comb begin
        evt.wr_ok = wr_en && !full;
        evt.rd_ok = rd_en && !empty;
        evt.ovf   = wr_en && full;
        evt.udf   = rd_en && empty;
    end
endmodule

// File: rtl/fom_level_track.sv
module fom_level_track
    import fom_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_ok,
    input  logic             rd_ok,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] peak
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level_q, level_nxt;
    logic [LVL_W-1:0] peak_q, peak_nxt;

    always_comb begin
        level_nxt = level_q;
        unique case (step_of(wr_ok, rd_ok))
            LVL_UP:   if (level_q != LVL_MAX) level_nxt = level_q + 1'b1;
            LVL_DOWN: if (level_q != '0)      level_nxt = level_q - 1'b1;
            default:  level_nxt = level_q;
        endcase
    end

    // the mark follows the new level so it moves on the same edge
    always_comb begin
        if (clr)                      peak_nxt = level_nxt;
        else if (level_nxt > peak_q)  peak_nxt = level_nxt;
        else                          peak_nxt = peak_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            peak_q  <= '0;
        end else begin
            level_q <= level_nxt;
            peak_q  <= peak_nxt;
        end
    end

    assign level = level_q;
    assign peak  = peak_q;
endmodule

// File: rtl/fom_err_log.sv
module fom_err_log #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hit,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             flag_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag_q  <= 1'b0;
            count_q <= '0;
        end else if (hit) begin
            flag_q <= 1'b1;
            if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
        end
    end

    assign flag  = flag_q;
    assign count = count_q;
endmodule

// File: rtl/fifo_occ_monitor.sv
module fifo_occ_monitor
    import fom_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             full,
    input  logic             empty,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] peak,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic [CNT_W-1:0] ovf_count,
    output logic [CNT_W-1:0] udf_count
);
    fom_evt_t             evt;
    logic [ERR_KINDS-1:0] err_hit;
    logic [ERR_KINDS-1:0] err_flag;
    logic [CNT_W-1:0]     err_cnt [ERR_KINDS];

    fom_event_decode u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .full  (full),
        .empty (empty),
        .evt   (evt)
    );

    fom_level_track #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_level (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .wr_ok (evt.wr_ok),
        .rd_ok (evt.rd_ok),
        .level (level),
        .peak  (peak)
    );

    assign err_hit[ERR_OVF] = evt.ovf;
    assign err_hit[ERR_UDF] = evt.udf;

    for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
        fom_err_log #(
            .CNT_W (CNT_W)
        ) u_log (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .hit   (err_hit[k]),
            .flag  (err_flag[k]),
            .count (err_cnt[k])
        );
    end

    assign ovf_flag  = err_flag[ERR_OVF];
    assign udf_flag  = err_flag[ERR_UDF];
    assign ovf_count = err_cnt[ERR_OVF];
    assign udf_count = err_cnt[ERR_UDF];
endmodule

// File: rtl/fom_checker.sv
module fom_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             empty,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] peak,
    input logic             ovf_flag,
    input logic             udf_flag,
    input logic [CNT_W-1:0] ovf_count,
    input logic [CNT_W-1:0] udf_count
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_level_up_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !(rd_en && !empty) && level != LVL_MAX)
        |=> level == $past(level) + 1'b1);

    assert_level_down_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty && !(wr_en && !full) && level != '0)
        |=> level == $past(level) - 1'b1);

    assert_both_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && rd_en && !empty) |=> $stable(level));

    assert_rejected_R5: assert property (@(posedge clk) disable iff (rst)
        ((wr_en && full && !(rd_en && !empty)) || (rd_en && empty && !(wr_en && !full)))
        |=> $stable(level));

    assert_level_range_R6: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_MAX);

    assert_peak_cover_R7: assert property (@(posedge clk) disable iff (rst)
        peak >= level);

    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !clr) |=> ovf_flag);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr) |=> ovf_flag);

    assert_udf_set_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !clr) |=> udf_flag);

    assert_ovf_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf_count == CNT_MAX && !clr) |=> ovf_count == CNT_MAX);

    assert_udf_nodec_R10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> udf_count >= $past(udf_count));

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ovf_flag && !udf_flag && ovf_count == '0 && udf_count == '0
                 && peak == level));
endmodule

bind fifo_occ_monitor fom_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_fom_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .full      (full),
    .empty     (empty),
    .level     (level),
    .peak      (peak),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag),
    .ovf_count (ovf_count),
    .udf_count (udf_count)
);

// File: tb/fifo_occ_monitor_tb.sv
`timescale 1ns/1ps
module fifo_occ_monitor_tb;
    localparam int DEPTH = 16;
    localparam int CNT_W = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, full = 1'b0, empty = 1'b1;
    logic [LVL_W-1:0] level, peak;
    logic ovf_flag, udf_flag;
    logic [CNT_W-1:0] ovf_count, udf_count;

    int n_chk = 0, n_fail = 0;
    int m_lvl = 0, m_pk = 0, m_of = 0, m_uf = 0, m_oc = 0, m_uc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    fifo_occ_monitor #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
        .full(full), .empty(empty), .level(level), .peak(peak),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag),
        .ovf_count(ovf_count), .udf_count(udf_count)
    );

    function automatic int next_level(int lv, bit w, bit r, bit f, bit e);
        bit wa = w && !f;
        bit ra = r && !e;
        if (wa && !ra && lv < DEPTH) return lv + 1;
        if (ra && !wa && lv > 0)     return lv - 1;
        return lv;
    endfunction

    function automatic int sat_inc(int c);
        return (c < CNT_MAX) ? c + 1 : c;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "level", int'(level), m_lvl);
        chk(req, "peak", int'(peak), m_pk);
        chk(req, "ovf_flag", int'(ovf_flag), m_of);
        chk(req, "udf_flag", int'(udf_flag), m_uf);
        chk(req, "ovf_count", int'(ovf_count), m_oc);
        chk(req, "udf_count", int'(udf_count), m_uc);
    endtask

    // one observed cycle: drive at negedge, update model at posedge, compare after it
    task automatic step(bit w, bit r, bit f, bit e, bit c, string req);
        @(negedge clk);
        wr_en = w; rd_en = r; full = f; empty = e; clr = c;
        @(posedge clk);
        m_lvl = next_level(m_lvl, w, r, f, e);
        if (c) begin
            m_pk = m_lvl; m_of = 0; m_uf = 0; m_oc = 0; m_uc = 0;
        end else begin
            if (m_lvl > m_pk) m_pk = m_lvl;
            if (w && f) begin m_of = 1; m_oc = sat_inc(m_oc); end
            if (r && e) begin m_uf = 1; m_uc = sat_inc(m_uc); end
        end
        #1;
        check_all(req);
    endtask

    task automatic step_cons(bit w, bit r, bit c, string req);
        step(w, r, m_lvl == DEPTH, m_lvl == 0, c, req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check_all("R1 reset");

        // R2 / R7: fill to the top
        for (int i = 0; i < DEPTH; i++) step_cons(1, 0, 0, "R2 R7 fill");
        // R5 R8: write while full rejected and logged
        step_cons(1, 0, 0, "R5 R8 write while full");
        // R6: inconsistent full low at DEPTH, level clamps
        step(1, 0, 0, 0, 0, "R6 clamp high");
        // R3: read down
        for (int i = 0; i < 3; i++) step_cons(0, 1, 0, "R3 drain");
        // R4: simultaneous accepted write and read
        step_cons(1, 1, 0, "R4 both accepted");
        // R7: peak stays at DEPTH
        for (int i = 0; i < DEPTH - 3; i++) step_cons(0, 1, 0, "R3 R7 drain");
        // R9 R5: read while empty
        step_cons(0, 1, 0, "R5 R9 read while empty");
        // R6: inconsistent empty low at zero, level clamps
        step(0, 1, 0, 0, 0, "R6 clamp low");
        // R10: saturate underflow count
        for (int i = 0; i < CNT_MAX + 4; i++) step(0, 1, 0, 1, 0, "R10 saturate");
        // R10: both errors in one cycle
        step(1, 1, 1, 1, 0, "R10 both errors");
        // R11: clear with an error in the same cycle
        step_cons(1, 0, 0, "R2 pre-clear");
        step(1, 0, 1, 0, 1, "R11 clear wins");
        step_cons(1, 0, 0, "R11 peak restarts");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit w = ($urandom % 100) < 55;
            bit r = ($urandom % 100) < 45;
            bit c = ($urandom % 100) < 2;
            if (($urandom % 100) < 90) step_cons(w, r, c, "R2 R3 R7 R10 random");
            else step(w, r, 1'($urandom), 1'($urandom), c, "R5 R6 R8 R9 R11 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule